// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block is an 8-bit counter attached to one external input pin. It works in one of two modes. In event mode it counts transitions of the pin in one chosen direction. In gated mode it measures how long the pin stays at an active level. It does this by adding one for every 64 clocks that pass while the pin is active. A single polarity bit serves both modes. In event mode it picks the edge that is counted. In gated mode it picks which pin level stops the count.

The block keeps two sticky status flags, each with its own interrupt enable. The input flag marks the programmed transition. The overflow flag marks a wrap of the counter. An optional saturating limit holds the count at its maximum instead of letting it wrap. A read-only holding register takes a snapshot of the count whenever an external latch strobe arrives. The pin passes through a synchronizer before any logic uses it. The divide-by-64 timebase runs freely from reset.

Top module: `pulse_accum`

## Requirements
- R1: After reset the configuration reads 0: disabled, event mode, falling-edge selection, saturation off, both interrupt enables off. The count, the holding value, both flags and both interrupt outputs are 0.
- R2: The configuration word has six fields: bit 0 enable, bit 1 gated mode, bit 2 polarity, bit 3 saturate, bit 4 input interrupt enable, bit 5 overflow interrupt enable. When enabled in event mode, each falling edge (polarity 0) or each rising edge (polarity 1) of the synchronized pin adds one to the count.
- R3: When enabled in gated mode, the count adds one on each timebase tick while the synchronized pin is active. The pin is active when high for polarity 0 and when low for polarity 1. While the pin is inactive the count does not move.
- R4: The timebase ticks on the 64th clock after reset release and on every 64th clock after that. A gate opening or closing does not realign it.
- R5: When enabled, the input flag sets on the programmed transition: the selected edge in event mode, and the trailing edge of the active level in gated mode (falling for polarity 0, rising for polarity 1).
- R6: An increment from 0xFF without saturation wraps the count to 0x00 and sets the overflow flag.
- R7: With the saturate bit set, an increment at 0xFF leaves the count at 0xFF and does not set the overflow flag.
- R8: A one-cycle clear pulse on a flag's clear input clears that flag. A set event in the same cycle wins, and the flag stays 1.
- R9: Each interrupt output is high exactly while its flag and its enable bit are both 1.
- R10: A latch strobe copies the count held in that cycle into the holding register. Without a strobe the holding register does not change.
- R11: While the enable bit is 0, the count does not change and neither flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 6 | Configuration word (fields as in R2) |
| pin_i | input | 1 | Asynchronous accumulator input pin |
| in_clr_i | input | 1 | Write-one clear of the input flag |
| ovf_clr_i | input | 1 | Write-one clear of the overflow flag |
| latch_i | input | 1 | Holding register latch strobe |
| cfg_o | output | 6 | Current configuration |
| count_o | output | 8 | Accumulator count |
| hold_o | output | 8 | Holding register |
| in_flag_o | output | 1 | Input transition flag |
| ovf_flag_o | output | 1 | Overflow flag |
| in_irq_o | output | 1 | Input interrupt request |
| ovf_irq_o | output | 1 | Overflow interrupt request |

## Verification
The assertions check the following on every cycle:
- the count only ever steps by one, modulo 256;
- the count freezes while disabled, while the gate is inactive, and at 0xFF under saturation;
- a wrap always raises the overflow flag;
- the holding register changes only on a strobe;
- a clear without a competing set drops its flag;
- timebase ticks are isolated.

Only the bench's scenarios can show how the timebase is aligned to reset, the exact latency from pin to count, and which edge each polarity selects. The same holds for the measured gate length, the clear-versus-set collision, and the reset values.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int CFG_W = 6;

  typedef struct packed {
    logic ovf_ie;
    logic in_ie;
    logic sat;
    logic pol;
    logic gated;
    logic en;
  } pa_cfg_t;
endpackage

// File: rtl/pa_sync_edge.sv
module pa_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], pin_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

  a_r5_edge_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pa_prescale.sv
module pa_prescale #(
  parameter int DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] div_q;

  assign tick_o = (div_q == LAST);

  // free-running: never realigned by the gate
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + W'(1);

  a_r4_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/pa_core.sv
module pa_core
  import pa_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pa_cfg_t          cfg_i,
  input  logic             level_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             tick_i,
  input  logic             in_clr_i,
  input  logic             ovf_clr_i,
  input  logic             latch_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] hold_o,
  output logic             in_flag_o,
  output logic             ovf_flag_o
);
  logic [CNT_W-1:0] cnt_q, hold_q;
  logic in_q, ovf_q;
  logic trans, active, inc, at_max, set_in, set_ovf, stuck;

  // same transition serves edge select and gate trailing edge
  assign trans   = cfg_i.pol ? rise_i : fall_i;
  assign active  = level_i ^ cfg_i.pol;
  assign inc     = cfg_i.en & (cfg_i.gated ? (active & tick_i) : trans);
  assign set_in  = cfg_i.en & trans;
  assign at_max  = &cnt_q;
  assign stuck   = at_max & cfg_i.sat;
  assign set_ovf = inc & at_max & ~cfg_i.sat;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            cnt_q <= '0;
    else if (inc && !stuck) cnt_q <= cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      hold_q <= '0;
    else if (latch_i) hold_q <= cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      in_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      in_q  <= set_in  | (in_q  & ~in_clr_i);
      ovf_q <= set_ovf | (ovf_q & ~ovf_clr_i);
    end

  assign cnt_o      = cnt_q;
  assign hold_o     = hold_q;
  assign in_flag_o  = in_q;
  assign ovf_flag_o = ovf_q;

  a_r2_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_q) |-> cnt_q == $past(cnt_q) + CNT_W'(1));
  a_r3_gate_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && cfg_i.gated && !active) |=> $stable(cnt_q));
  a_r6_wrap_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && at_max && !cfg_i.sat) |=> (cnt_q == '0 && ovf_q));
  a_r7_sat_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_max && cfg_i.sat) |=> (&cnt_q));
  a_r8_in_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_clr_i && !set_in) |=> !in_q);
  a_r10_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(hold_q));
  a_r11_idle_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |=> ($stable(cnt_q) && !$rose(in_q) && !$rose(ovf_q)));
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pa_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DIV         = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             pin_i,
  input  logic             in_clr_i,
  input  logic             ovf_clr_i,
  input  logic             latch_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] hold_o,
  output logic             in_flag_o,
  output logic             ovf_flag_o,
  output logic             in_irq_o,
  output logic             ovf_irq_o
);
  pa_cfg_t cfg_q;
  logic level, rise, fall, tick;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= pa_cfg_t'(cfg_wdata_i);

  pa_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i,
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  pa_prescale #(.DIV(DIV)) u_div (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  pa_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni,
    .cfg_i(cfg_q), .level_i(level), .rise_i(rise), .fall_i(fall),
    .tick_i(tick), .in_clr_i, .ovf_clr_i, .latch_i,
    .cnt_o(count_o), .hold_o, .in_flag_o, .ovf_flag_o
  );

  assign cfg_o     = cfg_q;
  assign in_irq_o  = in_flag_o  & cfg_q.in_ie;
  assign ovf_irq_o = ovf_flag_o & cfg_q.ovf_ie;

  a_r9_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q.in_ie && !cfg_q.ovf_ie) |-> (!in_irq_o && !ovf_irq_o));
endmodule

// File: tb/pulse_accum_tb.sv
`timescale 1ns/1ps
module pulse_accum_tb;
  localparam int EN = 1, GATED = 2, POL = 4, SAT = 8, INIE = 16, OVIE = 32;

  logic clk = 0, rst_ni = 0;
  logic cfg_we = 0, pin = 0, in_clr = 0, ovf_clr = 0, latch = 0;
  logic [5:0] cfg_wdata = 0;
  logic [5:0] cfg_o;
  logic [7:0] count_o, hold_o;
  logic in_flag_o, ovf_flag_o, in_irq_o, ovf_irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pulse_accum u_dut (
    .clk_i(clk), .rst_ni, .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .pin_i(pin), .in_clr_i(in_clr), .ovf_clr_i(ovf_clr), .latch_i(latch),
    .cfg_o, .count_o, .hold_o, .in_flag_o, .ovf_flag_o, .in_irq_o, .ovf_irq_o
  );

  // behavioural reference
  int m_cfg, m_cnt, m_hold, m_inf, m_ovf, m_cyc;
  int pin_hist[$];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cfg = 0; m_cnt = 0; m_hold = 0; m_inf = 0; m_ovf = 0; m_cyc = 0;
      pin_hist = {0, 0, 0};
    end else begin
      int b2, b3, pol, trans, act, tick, inc, setov;
      b2 = pin_hist[1]; b3 = pin_hist[2];   // pin two and three edges ago
      pol = (m_cfg & POL) != 0;
      trans = pol ? (b2 && !b3) : (!b2 && b3);
      act = (b2 != pol);
      tick = (m_cyc % 64) == 63;
      m_cyc++;
      inc = (m_cfg & EN) && ((m_cfg & GATED) ? (act && tick) : trans);
      setov = 0;
      if (latch) m_hold = m_cnt;
      if (inc) begin
        if (m_cnt == 255) begin
          if (!(m_cfg & SAT)) begin m_cnt = 0; setov = 1; end
        end else m_cnt++;
      end
      m_inf = ((m_cfg & EN) && trans) ? 1 : (in_clr ? 0 : m_inf);
      m_ovf = setov ? 1 : (ovf_clr ? 0 : m_ovf);
      if (cfg_we) m_cfg = cfg_wdata;
      pin_hist.push_front(int'(pin));
      void'(pin_hist.pop_back());
    end
  end

  task automatic chk(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) if (rst_ni && !done) begin
    chk(count_o, m_cnt, (m_cfg & GATED) ? "R4 gated count" : "R2 count");
    chk(hold_o, m_hold, "R10 hold");
    chk(in_flag_o, m_inf, "R5 input flag");
    chk(ovf_flag_o, m_ovf, "R6 overflow flag");
    chk(in_irq_o, m_inf && (m_cfg & INIE), "R9 input irq");
    chk(ovf_irq_o, m_ovf && (m_cfg & OVIE), "R9 overflow irq");
    chk(cfg_o, m_cfg, "R1 cfg");
  end

  task automatic wcfg(int v);
    cfg_wdata = 6'(v); cfg_we = 1; @(negedge clk); cfg_we = 0;
  endtask
  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      pin = 1; repeat (4) @(negedge clk);
      pin = 0; repeat (4) @(negedge clk);
    end
  endtask
  task automatic clr_in();  in_clr = 1;  @(negedge clk); in_clr = 0;  @(negedge clk); endtask
  task automatic clr_ovf(); ovf_clr = 1; @(negedge clk); ovf_clr = 0; @(negedge clk); endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_o, 0, "R1 cfg reset"); chk(count_o, 0, "R1 count reset");
    chk(hold_o, 0, "R1 hold reset");
    chk(in_flag_o | ovf_flag_o | in_irq_o | ovf_irq_o, 0, "R1 flags reset");
    // R2 falling edges
    wcfg(EN); pulses(5);
    chk(count_o, 5, "R2 falling edges");
    chk(in_flag_o, 1, "R5 event flag");
    clr_in(); chk(in_flag_o, 0, "R8 write-one clear");
    // R2 rising edges
    wcfg(EN | POL); pulses(3);
    chk(count_o, 8, "R2 rising edges");
    clr_in();
    // R11 disabled
    wcfg(POL); pulses(3);
    chk(count_o, 8, "R11 no count when disabled");
    chk(in_flag_o, 0, "R11 no flag when disabled");
    // R10 latch
    latch = 1; @(negedge clk); latch = 0; @(negedge clk);
    chk(hold_o, 8, "R10 latch captures");
    wcfg(EN | POL | INIE | OVIE); pulses(2);
    chk(count_o, 10, "R2 count resumes");
    chk(hold_o, 8, "R10 hold unchanged");
    chk(in_irq_o, 1, "R9 input irq");
    // R6 overflow
    clr_in(); pulses(246);
    chk(count_o, 0, "R6 wrap to zero");
    chk(ovf_flag_o, 1, "R6 overflow flag");
    chk(ovf_irq_o, 1, "R9 overflow irq");
    // R7 saturation
    clr_ovf(); wcfg(EN | POL | SAT); pulses(260);
    chk(count_o, 255, "R7 saturates");
    chk(ovf_flag_o, 0, "R7 no overflow flag");
    // R8 set beats clear
    wcfg(EN); clr_in();
    pin = 1; repeat (4) @(negedge clk);
    pin = 0; @(negedge clk); @(negedge clk);
    in_clr = 1; @(negedge clk); in_clr = 0; @(negedge clk);
    chk(in_flag_o, 1, "R8 set wins over clear");
    // R3 gated, active high
    clr_in(); wcfg(EN | GATED);
    c0 = count_o;
    pin = 1; repeat (640) @(negedge clk);
    pin = 0; repeat (6) @(negedge clk);
    c0 = (int'(count_o) - c0) & 255;
    checks++;
    if (c0 < 9 || c0 > 11) begin
      errors++; $display("FAIL R3 gated length actual=%0d expected=9..11", c0);
    end
    chk(in_flag_o, 1, "R5 trailing edge flag");
    // R3 gated, polarity 1 inhibits while high
    clr_in(); wcfg(EN | GATED | POL);
    c0 = count_o;
    pin = 1; repeat (640) @(negedge clk);
    chk(count_o, c0, "R3 inhibited while high");
    pin = 0; repeat (200) @(negedge clk);
    pin = 1; repeat (6) @(negedge clk);
    chk(in_flag_o, 1, "R5 trailing edge polarity 1");
    repeat (4) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule